// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the state changes a 32-bit embedded core makes when it enters an exception or interrupt handler. The core presents its current PC, status word, delay-slot count, current and kernel stack pointers, vector base and version number. It also presents four cause requests: bus fault, break, non-maskable interrupt (NMI) and external hard interrupt. Each request comes with its vector source. In the idle state the sequencer decides which cause it accepts. It latches the new architectural values that follow from that cause, then reads the handler address from instruction memory over a request/valid handshake.

When the read returns, the sequencer drives the handler address as the new PC and pulses `done` for one cycle. In that same cycle it pulses write strobes that tell the core which return register, user stack pointer and delay-slot state to update. A faulting handler read produces an `err` pulse in place of `done`. The core then decides how to recover.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done`, `err` and every strobe are low, and `pc_out`, `ccs_out`, `sp_out`, `usp_out`, `ret_addr`, `exs_out` and `mem_addr` are zero.
- R2: A hard interrupt request is accepted only when status bit 4 (interrupt enable) is set and `irq_lock` is low. Otherwise it is ignored and `busy` stays low.
- R3: An NMI request is accepted only when its mask flag is set in the status word. The flag is bit 9 when `ver_in` < 32 and bit 30 otherwise.
- R4: Among accepted causes, bus fault wins over break, break over NMI, and NMI over hard interrupt. The vector is `fault_vec`, `trap_vec`, 0 or `irq_vec`, in that order.
- R5: At `done`, an NMI entry pulses `nrp_we`. Any other entry pulses `erp_we`. Exactly one of the two is high.
- R6: `ret_addr` equals `pc_in` minus `dslot_in`. `dslot_clr` pulses with `done` exactly when `dslot_in` was nonzero.
- R7: `exs_out` holds the low 8 bits of the vector in bits 15:8, with every other bit zero.
- R8: If status bit 8 (user mode) is set, `usp_out` takes `sp_in`, `sp_out` takes `ksp_in` and `usp_we` pulses with `done`. Otherwise `sp_out` takes `sp_in`, `usp_out` keeps its value and `usp_we` stays low.
- R9: `ccs_out` equals the status word with bits 31:30 kept, bits 19:0 moved to 29:10 and bits 9:0 cleared. For an NMI, the selected mask flag is cleared before the move.
- R10: Starting on the cycle after acceptance, `mem_req` stays high with `mem_addr` = `ebp_in` + 4×vector until a cycle with `mem_valid` high. On the next cycle `done` pulses and `pc_out` holds `mem_rdata`.
- R11: If `mem_err` is high with `mem_valid`, `err` pulses in place of `done`. No strobe fires, `pc_out` is unchanged and the block returns to idle.
- R12: Requests raised while `busy` is high are ignored. The latched outputs and `mem_addr` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_bus | input | 1 | Bus fault pending |
| req_brk | input | 1 | Break pending |
| req_nmi | input | 1 | NMI pending |
| req_irq | input | 1 | Hard interrupt pending |
| irq_lock | input | 1 | Hard interrupts locked out |
| fault_vec | input | 8 | Vector latched by the translation fault |
| trap_vec | input | 8 | Break vector |
| irq_vec | input | 8 | Vector from the interrupt controller |
| ver_in | input | 8 | Version register |
| pc_in | input | 32 | Current PC |
| ccs_in | input | 32 | Current status word |
| dslot_in | input | 2 | Delay-slot count, 0 when not in a slot |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| ebp_in | input | 32 | Vector table base |
| mem_req | output | 1 | Handler address read request |
| mem_addr | output | 32 | Handler address read address |
| mem_valid | input | 1 | Read data valid |
| mem_err | input | 1 | Read faulted |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle pulse, new PC loaded |
| err | output | 1 | One-cycle pulse, handler read faulted |
| pc_out | output | 32 | New PC (handler address) |
| ccs_out | output | 32 | New status word |
| sp_out | output | 32 | New stack pointer |
| usp_out | output | 32 | Saved user stack pointer |
| ret_addr | output | 32 | Return address to save |
| exs_out | output | 32 | Exception status value |
| erp_we | output | 1 | Write `ret_addr` to the exception return register |
| nrp_we | output | 1 | Write `ret_addr` to the NMI return register |
| usp_we | output | 1 | Write `usp_out` to the user stack pointer register |
| dslot_clr | output | 1 | Clear the delay-slot indicator |

## Verification
The hardest condition to reach is a request that arrives while an entry is already waiting on a slow handler read. Such a request must leave every latched result and the read address untouched. The bench reaches it by stretching the memory latency and injecting all four causes with fresh vectors in the middle of the wait. A second subtle case is an NMI gated by the mask bit that the version register selects. The sweep covers every combination of the four requests, both lock states, both sides of the version boundary and every setting of the enable, user and two mask bits. This exercises both mask positions, and it also covers the case where the old-version mask bit survives the shift when the newer bit is the one in use.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int VW        = 8,
  parameter int DSW       = 2,
  parameter int VERW      = 8,
  parameter int I_BIT     = 4,
  parameter int U_BIT     = 8,
  parameter int M_OLD     = 9,
  parameter int M_NEW     = 30,
  parameter int VER_SPLIT = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_bus,
  input  logic            req_brk,
  input  logic            req_nmi,
  input  logic            req_irq,
  input  logic            irq_lock,
  input  logic [VW-1:0]   fault_vec,
  input  logic [VW-1:0]   trap_vec,
  input  logic [VW-1:0]   irq_vec,
  input  logic [VERW-1:0] ver_in,
  input  logic [31:0]     pc_in,
  input  logic [31:0]     ccs_in,
  input  logic [DSW-1:0]  dslot_in,
  input  logic [31:0]     sp_in,
  input  logic [31:0]     ksp_in,
  input  logic [31:0]     ebp_in,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_valid,
  input  logic            mem_err,
  input  logic [31:0]     mem_rdata,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [31:0]     pc_out,
  output logic [31:0]     ccs_out,
  output logic [31:0]     sp_out,
  output logic [31:0]     usp_out,
  output logic [31:0]     ret_addr,
  output logic [31:0]     exs_out,
  output logic            erp_we,
  output logic            nrp_we,
  output logic            usp_we,
  output logic            dslot_clr
);

  localparam logic [VERW-1:0] SPLIT_V = VERW'(VER_SPLIT);
  localparam int              PADW    = 32 - VW - 2;

  typedef enum logic {S_IDLE, S_FETCH} state_t;
  state_t state;

  logic          nmi_q, swap_q, ds_q;
  logic [31:0]   m_mask, ccs_m, ccs_sh;
  logic [VW-1:0] vec;
  logic [7:0]    vec_lo;
  logic          irq_ok, nmi_ok, take_nmi, start;

  assign m_mask   = (ver_in < SPLIT_V) ? (32'd1 << M_OLD) : (32'd1 << M_NEW);
  assign irq_ok   = req_irq & ccs_in[I_BIT] & ~irq_lock;
  assign nmi_ok   = req_nmi & |(ccs_in & m_mask);
  assign take_nmi = ~req_bus & ~req_brk & nmi_ok;
  assign start    = (state == S_IDLE) & (req_bus | req_brk | nmi_ok | irq_ok);

  always_comb begin
    if (req_bus)      vec = fault_vec;
    else if (req_brk) vec = trap_vec;
    else if (nmi_ok)  vec = '0;
    else              vec = irq_vec;
  end

  assign vec_lo = 8'(vec);
  assign ccs_m  = take_nmi ? (ccs_in & ~m_mask) : ccs_in;
  assign ccs_sh = {ccs_m[31:30], ccs_m[19:0], 10'd0};

  assign busy      = (state == S_FETCH);
  assign mem_req   = busy;
  assign erp_we    = done & ~nmi_q;
  assign nrp_we    = done & nmi_q;
  assign usp_we    = done & swap_q;
  assign dslot_clr = done & ds_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      err      <= 1'b0;
      nmi_q    <= 1'b0;
      swap_q   <= 1'b0;
      ds_q     <= 1'b0;
      pc_out   <= '0;
      ccs_out  <= '0;
      sp_out   <= '0;
      usp_out  <= '0;
      ret_addr <= '0;
      exs_out  <= '0;
      mem_addr <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (start) begin
        state    <= S_FETCH;
        nmi_q    <= take_nmi;
        ds_q     <= |dslot_in;
        ret_addr <= pc_in - 32'(dslot_in);
        exs_out  <= {16'd0, vec_lo, 8'd0};
        ccs_out  <= ccs_sh;
        mem_addr <= ebp_in + {{PADW{1'b0}}, vec, 2'b00};
        swap_q   <= ccs_in[U_BIT];
        if (ccs_in[U_BIT]) begin
          usp_out <= sp_in;
          sp_out  <= ksp_in;
        end else begin
          sp_out  <= sp_in;
        end
      end else if (busy && mem_valid) begin
        state <= S_IDLE;
        if (mem_err) begin
          err <= 1'b1;
        end else begin
          done   <= 1'b1;
          pc_out <= mem_rdata;
        end
      end
    end
  end

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R10
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_valid && !mem_err));

  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R11
  err_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(mem_req && mem_valid && mem_err) && !busy && $stable(pc_out)));

  // R5
  ret_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({erp_we, nrp_we}) == 1);

  // R9
  ccs_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ccs_out[9:0] == 10'd0));

  // R7
  exs_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (exs_out[31:16] == 16'd0 && exs_out[7:0] == 8'd0));

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ccs_out) && $stable(exs_out) &&
                               $stable(ret_addr) && $stable(sp_out)));

endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic req_bus, req_brk, req_nmi, req_irq, irq_lock;
  logic [7:0] fault_vec, trap_vec, irq_vec, ver_in;
  logic [31:0] pc_in, ccs_in, sp_in, ksp_in, ebp_in;
  logic [1:0] dslot_in;
  logic mem_req, mem_valid, mem_err;
  logic [31:0] mem_addr, mem_rdata;
  logic busy, done, err, erp_we, nrp_we, usp_we, dslot_clr;
  logic [31:0] pc_out, ccs_out, sp_out, usp_out, ret_addr, exs_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] usp_model = 32'd0;
  logic [31:0] pc_model  = 32'd0;

  always #4 clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n),
    .req_bus(req_bus), .req_brk(req_brk), .req_nmi(req_nmi), .req_irq(req_irq),
    .irq_lock(irq_lock), .fault_vec(fault_vec), .trap_vec(trap_vec),
    .irq_vec(irq_vec), .ver_in(ver_in), .pc_in(pc_in), .ccs_in(ccs_in),
    .dslot_in(dslot_in), .sp_in(sp_in), .ksp_in(ksp_in), .ebp_in(ebp_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .err(err), .pc_out(pc_out), .ccs_out(ccs_out), .sp_out(sp_out),
    .usp_out(usp_out), .ret_addr(ret_addr), .exs_out(exs_out),
    .erp_we(erp_we), .nrp_we(nrp_we), .usp_we(usp_we), .dslot_clr(dslot_clr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic clear_reqs();
    req_bus = 0; req_brk = 0; req_nmi = 0; req_irq = 0;
  endtask

  task automatic run_case(input int n);
    logic b, k, nm, iq, lk, old_ver, acc, is_nmi, ok_nmi, ok_irq, fault, noise;
    logic [31:0] mmask, cm, exp_ccs, rdata;
    logic [7:0] v;
    int lat;
    b  = n[0]; k = n[1]; nm = n[2]; iq = n[3]; lk = n[4]; old_ver = n[5];
    ccs_in = 32'h8AC3_5000 ^ {22'd0, n[6], 8'd0} ^ {n[7], 30'd0} ^ {23'd0, n[8], 8'd0}
             ^ {27'd0, n[9], 4'd0};
    ccs_in[9]  = n[6];
    ccs_in[30] = n[7];
    ccs_in[8]  = n[8];
    ccs_in[4]  = n[9];
    ver_in    = old_ver ? 8'd31 : 8'd32;
    irq_lock  = lk;
    fault_vec = 8'(n * 7 + 3);
    trap_vec  = 8'(n * 11 + 1);
    irq_vec   = 8'(n * 5 + 200);
    pc_in     = 32'h4000_0000 + 32'(n * 16);
    dslot_in  = 2'(n * 3);
    sp_in     = 32'h1000_0000 + 32'(n);
    ksp_in    = 32'h2000_0000 + 32'(n * 2);
    ebp_in    = 32'h0800_0000 + 32'(n * 64);
    lat   = n % 3;
    fault = (n % 13) == 5;
    noise = lat > 0 && n[2];
    rdata = 32'hC000_0001 ^ 32'(n * 32'h0001_0101);

    mmask  = old_ver ? 32'h0000_0200 : 32'h4000_0000;
    ok_nmi = nm && ((ccs_in & mmask) != 0);
    ok_irq = iq && ccs_in[4] && !lk;
    acc    = b || k || ok_nmi || ok_irq;
    is_nmi = !b && !k && ok_nmi;
    v = b ? fault_vec : k ? trap_vec : ok_nmi ? 8'd0 : irq_vec;
    cm = is_nmi ? (ccs_in & ~mmask) : ccs_in;
    exp_ccs = {cm[31:30], cm[19:0], 10'd0};

    @(negedge clk);
    req_bus = b; req_brk = k; req_nmi = nm; req_irq = iq;
    @(negedge clk);
    clear_reqs();
    if (!acc) begin
      // R2 R3: refused request leaves the block idle
      chk("R2_R3 busy on refused request", {31'd0, busy}, 32'd0);
      return;
    end
    chk("R4_R10 mem_req after accept", {31'd0, mem_req}, 32'd1);
    chk("R4_R10 mem_addr", mem_addr, ebp_in + {22'd0, v, 2'b00});
    for (int i = 0; i < lat; i++) begin
      if (i == 0 && noise) begin
        // R12: requests injected while busy
        req_bus = 1; req_brk = 1; req_nmi = 1; req_irq = 1;
        fault_vec = 8'hEE; trap_vec = 8'hDD; irq_vec = 8'hCC;
      end
      @(negedge clk);
      clear_reqs();
      if (noise) chk("R12 mem_addr steady while busy", mem_addr, ebp_in + {22'd0, v, 2'b00});
    end
    mem_valid = 1; mem_err = fault; mem_rdata = rdata;
    @(negedge clk);
    mem_valid = 0; mem_err = 0;
    if (fault) begin
      chk("R11 err pulse", {31'd0, err}, 32'd1);
      chk("R11 no done/strobes", {27'd0, done, erp_we, nrp_we, usp_we, dslot_clr}, 32'd0);
      chk("R11 pc_out unchanged", pc_out, pc_model);
      chk("R11 back to idle", {31'd0, busy}, 32'd0);
      if (ccs_in[8]) usp_model = sp_in;
      return;
    end
    pc_model = rdata;
    chk("R10 done pulse", {30'd0, done, err}, 32'd2);
    chk("R10 pc_out", pc_out, rdata);
    chk("R5 return strobes", {30'd0, nrp_we, erp_we}, is_nmi ? 32'd2 : 32'd1);
    chk("R6 ret_addr", ret_addr, pc_in - 32'(dslot_in));
    chk("R6 dslot_clr", {31'd0, dslot_clr}, {31'd0, dslot_in != 0});
    chk("R7 exs_out", exs_out, {16'd0, v, 8'd0});
    chk("R9 ccs_out", ccs_out, exp_ccs);
    if (ccs_in[8]) usp_model = sp_in;
    chk("R8 sp_out", sp_out, ccs_in[8] ? ksp_in : sp_in);
    chk("R8 usp_out", usp_out, usp_model);
    chk("R8 usp_we", {31'd0, usp_we}, {31'd0, ccs_in[8]});
    @(negedge clk);
    chk("R10 done one cycle", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    rst_n = 0; clear_reqs(); irq_lock = 0; mem_valid = 0; mem_err = 0;
    mem_rdata = 0; fault_vec = 0; trap_vec = 0; irq_vec = 0; ver_in = 0;
    pc_in = 0; ccs_in = 0; dslot_in = 0; sp_in = 0; ksp_in = 0; ebp_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 control outputs", {25'd0, busy, mem_req, done, err, erp_we, nrp_we, usp_we}, 32'd0);
    chk("R1 dslot_clr", {31'd0, dslot_clr}, 32'd0);
    chk("R1 pc_out", pc_out, 32'd0);
    chk("R1 ccs_out", ccs_out, 32'd0);
    chk("R1 sp/usp", sp_out | usp_out, 32'd0);
    chk("R1 ret/exs/addr", ret_addr | exs_out | mem_addr, 32'd0);
    for (int n = 0; n < 1024; n++) run_case(n);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule